// File: doc/BRIEF.md
# Flash protection command sequence decoder

This block watches the write and read strobes of an asynchronous flash-style bus and decodes the multi-cycle sequences that control sector protection. Each sequence begins with two unlock writes and a command write. The cycles that follow are routed to a protection action: programming a protection bit, erasing all sector protection bits, reading a status indicator, or setting the protection lock. The block sends single-cycle request strobes to an external protection-bit store and returns status bits on the data bus.

The two strobes are synchronised into the block clock. Address and data are taken at the rising edge of the synchronised strobe, so the bus must hold them stable until that edge has been seen. After a program or erase action, the block enforces a minimum wait, counted in clock cycles, before it accepts the verify write. The wait lengths are given as parameters in nanoseconds and converted using the clock period. When no sequence is in progress, the block reports that the device is in array-read mode.

Top module: `prot_seq_decoder`

## Requirements
- R1: After reset, `array_mode` is 1, and `rd_valid`, `busy_err` and all request strobes are 0.
- R2: A sequence opens with a write of AAh at address 555h, then 55h at 2AAh, then a command byte at 555h. In these cycles only address bits 11:0 and data bits 7:0 are compared. Command bytes: 60h opens a protect action, 90h opens a status read, 78h sets the lock, 58h opens a lock-status read.
- R3: A write that does not match the expected unlock address or data returns the decoder to idle and raises no strobe. That write is not reused as the start of a new sequence.
- R4: A write whose data low byte is F0h, at any address and in any state, returns the decoder to idle (`array_mode` = 1).
- R5: After 60h, a fourth write of 68h raises `req_prog` for exactly one cycle. Its target comes from address bits 7:0 and its sector from bits 22:12. Target byte codes: 02h gives sector protection bit (`req_target`=0), 1Ah gives secure-sector bit (1), 0Ah gives password-mode lock (2), 12h gives persistent-mode lock (3). Any other target byte returns the decoder to idle.
- R6: After 60h, a fourth write of 60h at target byte 02h raises `req_erase_all` for one cycle. With any other target byte, no strobe is raised and the decoder returns to idle. The verify read after an erase reports DQ0 = 0 when all bits are clear.
- R7: A fifth write that arrives before the wait has expired is ignored and pulses `busy_err`. The sequence keeps waiting, and a later valid fifth write is still accepted.
- R8: After the wait has expired, a fifth write of 48h (program) or 40h (erase) at the same target byte arms the verify. The next read returns `st_bit` on DQ0 with `rd_valid` high for one cycle, and the decoder then returns to idle.
- R9: After command 90h, a read selects the target and sector from its address and returns that bit on DQ0.
- R10: Command 78h raises `req_lock_set` for one cycle on the third write. After command 58h, a read returns `st_lock` on DQ1 and 0 on DQ0.
- R11: The wait after a program action lasts `PROG_WAIT_NS` and the wait after an erase action lasts `ERASE_WAIT_NS`. Each is rounded up to whole clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| bus_we_n | input | 1 | Asynchronous write strobe, active low; a cycle completes on its rising edge |
| bus_re_n | input | 1 | Asynchronous read strobe, active low; a cycle completes on its rising edge |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rdata | output | DATA_W | Status data returned on a decoded read |
| rd_valid | output | 1 | One-cycle pulse when `bus_rdata` holds a fresh status |
| req_prog | output | 1 | Program request to the protection store |
| req_erase_all | output | 1 | Erase-all request for the sector protection bits |
| req_lock_set | output | 1 | Lock set request |
| req_target | output | 2 | Selected protection target, also used for status lookup |
| req_sector | output | ADDR_W-12 | Selected sector, also used for status lookup |
| st_bit | input | 1 | Store answer: value of the bit chosen by `req_target`/`req_sector` |
| st_lock | input | 1 | Store answer: protection lock state |
| busy_err | output | 1 | Pulse when a verify write arrives before its wait has expired |
| array_mode | output | 1 | High while no sequence is in progress |

## Verification
The bench drives unlock cycles with garbage in the ignored upper address and data bits. A decoder that compared full words would never fire the lock request. It breaks the second unlock write and then issues a command byte, to catch a design that either fires a strobe or restarts the sequence from a bad write. Verify writes are sent both early and late, and an erase verify is sent at a point between the two wait lengths. A timer that ignored the wait, or used the shorter wait for erase, would accept that write instead of flagging busy. A reset byte is sent in the middle of a wait, and the bench checks that the following verify write is ignored rather than arming a read.

// File: rtl/prot_seq_pkg.sv
package prot_seq_pkg;

  typedef enum logic [1:0] {
    TGT_PPB     = 2'd0,
    TGT_SECURE  = 2'd1,
    TGT_PWLOCK  = 2'd2,
    TGT_PERLOCK = 2'd3
  } tgt_e;

  typedef enum logic [3:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PROT, S_WAIT, S_VRD, S_STAT, S_LSTAT, S_RESP
  } state_e;

  localparam logic [11:0] UNL_A1 = 12'h555;
  localparam logic [11:0] UNL_A2 = 12'h2AA;
  localparam logic [7:0]  UNL_D1 = 8'hAA;
  localparam logic [7:0]  UNL_D2 = 8'h55;
  localparam logic [7:0]  CMD_PROT    = 8'h60;
  localparam logic [7:0]  CMD_STATUS  = 8'h90;
  localparam logic [7:0]  CMD_LOCKSET = 8'h78;
  localparam logic [7:0]  CMD_LSTATUS = 8'h58;
  localparam logic [7:0]  CMD_RESET   = 8'hF0;
  localparam logic [7:0]  ACT_PROG    = 8'h68;
  localparam logic [7:0]  ACT_ERASE   = 8'h60;
  localparam logic [7:0]  VFY_PROG    = 8'h48;
  localparam logic [7:0]  VFY_ERASE   = 8'h40;
  localparam logic [7:0]  TB_PPB      = 8'h02;

  function automatic logic tgt_valid(input logic [7:0] b);
    return (b == 8'h02) || (b == 8'h1A) || (b == 8'h0A) || (b == 8'h12);
  endfunction

  function automatic tgt_e tgt_code(input logic [7:0] b);
    case (b)
      8'h1A:   return TGT_SECURE;
      8'h0A:   return TGT_PWLOCK;
      8'h12:   return TGT_PERLOCK;
      default: return TGT_PPB;
    endcase
  endfunction

  function automatic int unsigned wait_cycles(input int unsigned ns, input int unsigned period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

endpackage

// File: rtl/prot_bus_sync.sv
module prot_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we_n,
  input  logic re_n,
  output logic ev_wr,
  output logic ev_rd
);
  logic [SYNC_STAGES-1:0] we_sh, re_sh;
  logic we_d, re_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_sh <= '1;
      re_sh <= '1;
      we_d  <= 1'b1;
      re_d  <= 1'b1;
    end else begin
      we_sh <= {we_sh[SYNC_STAGES-2:0], we_n};
      re_sh <= {re_sh[SYNC_STAGES-2:0], re_n};
      we_d  <= we_sh[SYNC_STAGES-1];
      re_d  <= re_sh[SYNC_STAGES-1];
    end
  end

  assign ev_wr = we_sh[SYNC_STAGES-1] & ~we_d;
  assign ev_rd = re_sh[SYNC_STAGES-1] & ~re_d;
endmodule

// File: rtl/prot_wait_timer.sv
module prot_wait_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            count <= '0;
    else if (load)         count <= load_val;
    else if (count != '0)  count <= count - 1'b1;
  end

  assign done = (count == '0) && !load;
endmodule

// File: rtl/prot_cmd_fsm.sv
module prot_cmd_fsm
  import prot_seq_pkg::*;
#(
  parameter int ADDR_W  = 23,
  parameter int DATA_W  = 16,
  parameter int CW      = 8,
  parameter int N_PROG  = 10,
  parameter int N_ERASE = 20,
  localparam int SEC_W  = ADDR_W - 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_wr,
  input  logic              ev_rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_lo,
  input  logic              timer_done,
  input  logic              st_bit,
  input  logic              st_lock,
  output logic              timer_load,
  output logic [CW-1:0]     timer_val,
  output logic              req_prog,
  output logic              req_erase_all,
  output logic              req_lock_set,
  output tgt_e              tgt,
  output logic [SEC_W-1:0]  sector,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              busy_err,
  output logic              array_mode
);
  state_e            state;
  logic              erasing, lock_rd;
  logic [11:0]       a12;
  logic [7:0]        abyte;
  logic [SEC_W-1:0]  asec;
  logic [7:0]        vfy_code;

  assign a12      = addr[11:0];
  assign abyte    = addr[7:0];
  assign asec     = addr[ADDR_W-1:12];
  assign vfy_code = erasing ? VFY_ERASE : VFY_PROG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      erasing       <= 1'b0;
      lock_rd       <= 1'b0;
      tgt           <= TGT_PPB;
      sector        <= '0;
      timer_load    <= 1'b0;
      timer_val     <= '0;
      req_prog      <= 1'b0;
      req_erase_all <= 1'b0;
      req_lock_set  <= 1'b0;
      rd_data       <= '0;
      rd_valid      <= 1'b0;
      busy_err      <= 1'b0;
    end else begin
      timer_load    <= 1'b0;
      req_prog      <= 1'b0;
      req_erase_all <= 1'b0;
      req_lock_set  <= 1'b0;
      rd_valid      <= 1'b0;
      busy_err      <= 1'b0;
      if (ev_wr) begin
        if (wr_lo == CMD_RESET) begin
          state <= S_IDLE;
        end else begin
          case (state)
            S_IDLE: if (a12 == UNL_A1 && wr_lo == UNL_D1) state <= S_UNL1;
            S_UNL1: state <= (a12 == UNL_A2 && wr_lo == UNL_D2) ? S_UNL2 : S_IDLE;
            S_UNL2: begin
              state <= S_IDLE;
              if (a12 == UNL_A1) begin
                case (wr_lo)
                  CMD_PROT:    state <= S_PROT;
                  CMD_STATUS:  state <= S_STAT;
                  CMD_LSTATUS: state <= S_LSTAT;
                  CMD_LOCKSET: req_lock_set <= 1'b1;
                  default:     state <= S_IDLE;
                endcase
              end
            end
            S_PROT: begin
              if (wr_lo == ACT_PROG && tgt_valid(abyte)) begin
                tgt        <= tgt_code(abyte);
                sector     <= asec;
                erasing    <= 1'b0;
                req_prog   <= 1'b1;
                timer_load <= 1'b1;
                timer_val  <= CW'(N_PROG);
                state      <= S_WAIT;
              end else if (wr_lo == ACT_ERASE && abyte == TB_PPB) begin
                tgt           <= TGT_PPB;
                sector        <= asec;
                erasing       <= 1'b1;
                req_erase_all <= 1'b1;
                timer_load    <= 1'b1;
                timer_val     <= CW'(N_ERASE);
                state         <= S_WAIT;
              end else begin
                state <= S_IDLE;
              end
            end
            S_WAIT: begin
              if (!timer_done)
                busy_err <= 1'b1;
              else if (wr_lo == vfy_code && tgt_valid(abyte) && tgt_code(abyte) == tgt)
                state <= S_VRD;
              else
                state <= S_IDLE;
            end
            default: state <= S_IDLE;
          endcase
        end
      end else if (ev_rd) begin
        case (state)
          S_VRD: begin
            lock_rd <= 1'b0;
            state   <= S_RESP;
          end
          S_STAT: begin
            if (tgt_valid(abyte)) begin
              tgt     <= tgt_code(abyte);
              sector  <= asec;
              lock_rd <= 1'b0;
              state   <= S_RESP;
            end else begin
              state <= S_IDLE;
            end
          end
          S_LSTAT: begin
            lock_rd <= 1'b1;
            state   <= S_RESP;
          end
          default: ;
        endcase
      end else if (state == S_RESP) begin
        rd_valid <= 1'b1;
        rd_data  <= lock_rd ? {{(DATA_W-2){1'b0}}, st_lock, 1'b0}
                            : {{(DATA_W-1){1'b0}}, st_bit};
        state    <= S_IDLE;
      end
    end
  end

  assign array_mode = (state == S_IDLE);
endmodule

// File: rtl/prot_seq_decoder.sv
module prot_seq_decoder
  import prot_seq_pkg::*;
#(
  parameter int ADDR_W        = 23,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 20,
  parameter int PROG_WAIT_NS  = 100000,
  parameter int ERASE_WAIT_NS = 1200000,
  localparam int SEC_W   = ADDR_W - 12,
  localparam int N_PROG  = int'(wait_cycles(PROG_WAIT_NS, CLK_PERIOD_NS)),
  localparam int N_ERASE = int'(wait_cycles(ERASE_WAIT_NS, CLK_PERIOD_NS)),
  localparam int N_MAX   = (N_PROG > N_ERASE) ? N_PROG : N_ERASE,
  localparam int CW      = $clog2(N_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we_n,
  input  logic              bus_re_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rd_valid,
  output logic              req_prog,
  output logic              req_erase_all,
  output logic              req_lock_set,
  output logic [1:0]        req_target,
  output logic [SEC_W-1:0]  req_sector,
  input  logic              st_bit,
  input  logic              st_lock,
  output logic              busy_err,
  output logic              array_mode
);
  logic          ev_wr, ev_rd, timer_load, timer_done;
  logic [CW-1:0] timer_val;
  logic [7:0]    wr_lo;
  tgt_e          tgt;
  logic          unused_hi;

  assign wr_lo     = bus_wdata[7:0];
  assign unused_hi = ^bus_wdata[DATA_W-1:8];

  prot_bus_sync #(.SYNC_STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .we_n(bus_we_n), .re_n(bus_re_n),
    .ev_wr(ev_wr), .ev_rd(ev_rd)
  );

  prot_wait_timer #(.CW(CW)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(timer_val),
    .done(timer_done)
  );

  prot_cmd_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CW(CW),
    .N_PROG(N_PROG), .N_ERASE(N_ERASE)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .ev_wr(ev_wr), .ev_rd(ev_rd),
    .addr(bus_addr), .wr_lo(wr_lo), .timer_done(timer_done),
    .st_bit(st_bit), .st_lock(st_lock),
    .timer_load(timer_load), .timer_val(timer_val),
    .req_prog(req_prog), .req_erase_all(req_erase_all),
    .req_lock_set(req_lock_set), .tgt(tgt), .sector(req_sector),
    .rd_data(bus_rdata), .rd_valid(rd_valid), .busy_err(busy_err),
    .array_mode(array_mode)
  );

  assign req_target = tgt;
endmodule

// File: rtl/prot_seq_checker.sv
module prot_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_wr,
  input logic [7:0] wr_lo,
  input logic       req_prog,
  input logic       req_erase_all,
  input logic       req_lock_set,
  input logic       busy_err,
  input logic       rd_valid,
  input logic       array_mode
);
  AST_RESET_BYTE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr && wr_lo == 8'hF0) |=> array_mode); // R4
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_prog, req_erase_all, req_lock_set})); // R5
  AST_REQ_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_prog || req_erase_all || req_lock_set) |-> $past(ev_wr)); // R10
  AST_PROG_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_prog || req_erase_all) |-> !array_mode); // R6
  AST_BUSY_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err |-> ($past(ev_wr) && !array_mode)); // R7
  AST_READ_ENDS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> array_mode); // R8
endmodule

bind prot_seq_decoder prot_seq_checker chk_i (
  .clk(clk), .rst_n(rst_n), .ev_wr(ev_wr), .wr_lo(wr_lo),
  .req_prog(req_prog), .req_erase_all(req_erase_all),
  .req_lock_set(req_lock_set), .busy_err(busy_err),
  .rd_valid(rd_valid), .array_mode(array_mode)
);

// File: tb/prot_seq_decoder_tb.sv
module prot_seq_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 23;
  localparam int DW = 16;
  localparam int SW = AW - 12;
  localparam int PROG_CYC  = 40;   // 400 ns / 10 ns
  localparam int ERASE_CYC = 100;  // 1000 ns / 10 ns

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we_n = 1'b1, re_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rd_valid, req_prog, req_erase_all, req_lock_set, busy_err, array_mode;
  logic [1:0] req_target;
  logic [SW-1:0] req_sector;
  logic st_bit, st_lock;

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_seq_decoder #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(CLK_PERIOD),
    .PROG_WAIT_NS(400), .ERASE_WAIT_NS(1000)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we_n(we_n), .bus_re_n(re_n),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .rd_valid(rd_valid), .req_prog(req_prog), .req_erase_all(req_erase_all),
    .req_lock_set(req_lock_set), .req_target(req_target),
    .req_sector(req_sector), .st_bit(st_bit), .st_lock(st_lock),
    .busy_err(busy_err), .array_mode(array_mode)
  );

  // protection store model
  logic [(1<<SW)-1:0] ppb = '0;
  logic sec_b = 1'b0, pw_b = 1'b0, per_b = 1'b0, lock_b = 1'b0;
  logic store_en = 1'b1;
  int n_prog = 0, n_erase = 0, n_lock = 0, n_busy = 0, n_rd = 0;
  logic [DW-1:0] last_rd = '0;

  always_comb begin
    case (req_target)
      2'd1:    st_bit = sec_b;
      2'd2:    st_bit = pw_b;
      2'd3:    st_bit = per_b;
      default: st_bit = ppb[req_sector];
    endcase
  end
  assign st_lock = lock_b;

  always @(posedge clk) begin
    if (rst_n) begin
      if (req_prog) begin
        n_prog <= n_prog + 1;
        if (store_en) begin
          case (req_target)
            2'd1: sec_b <= 1'b1;
            2'd2: pw_b <= 1'b1;
            2'd3: per_b <= 1'b1;
            default: ppb[req_sector] <= 1'b1;
          endcase
        end
      end
      if (req_erase_all) begin n_erase <= n_erase + 1; if (store_en) ppb <= '0; end
      if (req_lock_set) begin n_lock <= n_lock + 1; lock_b <= 1'b1; end
      if (busy_err) n_busy <= n_busy + 1;
      if (rd_valid) begin n_rd <= n_rd + 1; last_rd <= rdata; end
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_read(input logic [AW-1:0] a);
    @(negedge clk);
    addr = a; re_n = 1'b0;
    repeat (2) @(negedge clk);
    re_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [AW-1:0] mk(input int sec, input logic [11:0] lo);
    return {SW'(sec), lo};
  endfunction

  task automatic unlock(input logic [7:0] cmd);
    bus_write(23'h7AB555, 16'h3CAA);
    bus_write(23'h0152AA, 16'hA555);
    bus_write(23'h3F0555, {8'hC3, cmd});
  endtask

  task automatic t_reset;
    chk(array_mode == 1'b1, "R1 array_mode", int'(array_mode), 1);
    chk(!rd_valid && !busy_err && !req_prog && !req_erase_all && !req_lock_set,
        "R1 outputs idle", int'({rd_valid, busy_err, req_prog, req_erase_all, req_lock_set}), 0);
  endtask

  task automatic t_unlock_mismatch;
    bus_write(12'h555, 16'h00AA);
    bus_write(12'h2AA, 16'h0056);
    chk(array_mode == 1'b1, "R3 idle after bad unlock", int'(array_mode), 1);
    bus_write(12'h555, 16'h0078);
    chk(n_lock == 0, "R3 no lock strobe", n_lock, 0);
    chk(array_mode == 1'b1, "R3 still idle", int'(array_mode), 1);
  endtask

  task automatic t_lock;
    unlock(8'h78);
    chk(n_lock == 1, "R2 R10 lock set with ignored upper bits", n_lock, 1);
    chk(array_mode == 1'b1, "R10 idle after lock set", int'(array_mode), 1);
    unlock(8'h58);
    bus_read(mk(0, 12'h002));
    chk(n_rd == 1 && last_rd == 16'h0002, "R10 lock status DQ1", int'(last_rd), 2);
  endtask

  task automatic t_program;
    unlock(8'h60);
    bus_write(mk(5, 12'h002), 16'h0068);
    chk(n_prog == 1, "R5 program strobe", n_prog, 1);
    chk(req_sector == SW'(5) && req_target == 2'd0, "R5 target/sector",
        int'({req_target, req_sector}), 5);
    bus_write(mk(5, 12'h002), 16'h0048);
    chk(n_busy == 1, "R7 early verify flagged", n_busy, 1);
    chk(array_mode == 1'b0, "R7 still waiting", int'(array_mode), 0);
    repeat (PROG_CYC + 10) @(negedge clk);
    bus_write(mk(5, 12'h002), 16'h0048);
    chk(n_busy == 1, "R7 late verify accepted", n_busy, 1);
    bus_read(mk(5, 12'h002));
    chk(n_rd == 2 && last_rd == 16'h0001, "R8 verify DQ0 success", int'(last_rd), 1);
    chk(array_mode == 1'b1, "R8 idle after verify", int'(array_mode), 1);
  endtask

  task automatic t_verify_fail;
    store_en = 1'b0;
    unlock(8'h60);
    bus_write(mk(0, 12'h01A), 16'h0068);
    chk(n_prog == 2 && req_target == 2'd1, "R5 secure target", int'(req_target), 1);
    repeat (PROG_CYC + 10) @(negedge clk);
    bus_write(mk(0, 12'h01A), 16'h0048);
    bus_read(mk(0, 12'h01A));
    chk(n_rd == 3 && last_rd == 16'h0000, "R8 verify DQ0 failure", int'(last_rd), 0);
    store_en = 1'b1;
  endtask

  task automatic t_status;
    unlock(8'h90);
    bus_read(mk(5, 12'h002));
    chk(n_rd == 4 && last_rd == 16'h0001, "R9 status set bit", int'(last_rd), 1);
    unlock(8'h90);
    bus_read(mk(6, 12'h002));
    chk(n_rd == 5 && last_rd == 16'h0000, "R9 status clear bit", int'(last_rd), 0);
  endtask

  task automatic t_erase;
    unlock(8'h60);
    bus_write(mk(0, 12'h01A), 16'h0060);
    chk(n_erase == 0 && array_mode == 1'b1, "R6 erase needs ppb target", n_erase, 0);
    unlock(8'h60);
    bus_write(mk(0, 12'h002), 16'h0060);
    chk(n_erase == 1, "R6 erase strobe", n_erase, 1);
    repeat (50) @(negedge clk);
    bus_write(mk(0, 12'h002), 16'h0040);
    chk(n_busy == 2, "R11 erase wait longer than program wait", n_busy, 2);
    repeat (ERASE_CYC) @(negedge clk);
    bus_write(mk(0, 12'h002), 16'h0040);
    bus_read(mk(0, 12'h002));
    chk(n_rd == 6 && last_rd == 16'h0000, "R6 erase verify DQ0 clear", int'(last_rd), 0);
  endtask

  task automatic t_reset_byte;
    unlock(8'h60);
    bus_write(mk(3, 12'h012), 16'h0068);
    chk(array_mode == 1'b0, "R4 in wait before reset byte", int'(array_mode), 0);
    bus_write(23'h12345, 16'hBEF0);
    chk(array_mode == 1'b1, "R4 reset byte returns idle", int'(array_mode), 1);
    bus_write(mk(3, 12'h012), 16'h0048);
    bus_read(mk(3, 12'h012));
    chk(n_busy == 2 && n_rd == 6, "R4 later verify ignored", n_rd, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unlock_mismatch();
    t_lock();
    t_program();
    t_verify_fail();
    t_status();
    t_erase();
    t_reset_byte();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule